// File: doc/BRIEF.md
# CAN Transmit Buffer Status Flags

This block keeps the handshake state of three CAN transmit message buffers for a host CPU. Each buffer has an empty flag, an abort-acknowledge flag and an abort-request bit. Software clears an empty flag to hand a loaded buffer to the transmit engine. The engine later reports one of two outcomes for that buffer: the frame went out, or a requested abort succeeded. The host reads every flag through one status byte. It can also raise one interrupt line per buffer while that buffer is empty.

Each buffer is tracked by a small state machine with four states:
- `BUF_IDLE_SENT`: empty, last frame was sent. This is the reset state.
- `BUF_IDLE_ABORTED`: empty, last frame was aborted.
- `BUF_QUEUED`: full, no abort requested.
- `BUF_ABORT_PEND`: full, abort requested.

The state machine has these transitions:
- Hand-off: a write-1 moves either idle state to `BUF_QUEUED`.
- Request: `BUF_QUEUED` moves to `BUF_ABORT_PEND` on an abort request.
- Done: a sent event moves `BUF_QUEUED` or `BUF_ABORT_PEND` to `BUF_IDLE_SENT`.
- Cancelled: an aborted event moves `BUF_ABORT_PEND` to `BUF_IDLE_ABORTED`.
- Flush: hard reset, or a held soft reset, puts every buffer in `BUF_IDLE_SENT`.

Top module: `txbuf_status_reg`

## Requirements
- R1: During hard reset, and on every cycle while `soft_rst` is 1, the block holds its reset values: `status` = 0x07, `abort_req` = 0. The hold takes effect at the clock edge.
- R2: Buffer i's empty flag reads on `status` bit i. Its abort-acknowledge flag reads on bit 4+i. Bits 7 and 3 always read 0.
- R3: A write (`wr_en`=1) with `wr_data` bit i = 1 clears empty flag i at the next edge. A 0 in that bit leaves the flag as it is. Bits 7..3 of `wr_data` have no effect.
- R4: When an empty flag is cleared, its abort-acknowledge flag is cleared at the same edge.
- R5: A `tx_sent` pulse for a full buffer sets its empty flag at the next edge, and leaves its abort-acknowledge flag at 0.
- R6: A `tx_aborted` pulse for a full buffer whose abort request is pending sets its empty flag and its abort-acknowledge flag at the next edge.
- R7: Whenever an empty flag becomes 1, the matching `abort_req` bit is 0 from that same edge.
- R8: `abort_set` bit i sets `abort_req` bit i only while empty flag i is 0. On an empty buffer it is ignored.
- R9: Ignored events:
  - Sent or aborted events for a buffer that is already empty change nothing.
  - An aborted event with no pending request changes nothing.
- R10: A write-1 to a full buffer in the same cycle as its sent event leaves that buffer empty.
- R11: `irq` bit i equals empty flag i AND `irq_en` bit i, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous hold-in-reset control |
| wr_en | input | 1 | CPU write strobe for the status byte |
| wr_data | input | 8 | CPU write data (write-1-to-clear on bits NBUF-1..0) |
| status | output | 8 | Status byte read by the CPU |
| abort_set | input | NBUF | CPU abort request per buffer |
| abort_req | output | NBUF | Pending abort request per buffer |
| tx_sent | input | NBUF | Engine pulse: frame sent |
| tx_aborted | input | NBUF | Engine pulse: abort succeeded |
| irq_en | input | NBUF | Interrupt enable per buffer |
| irq | output | NBUF | Masked interrupt per buffer |

## Verification
The bench builds the block with the default `NBUF` = 3. At that value every defined bit of the status byte is backed by a real buffer, and only bits 7 and 3 stay reserved. This lets the byte layout be checked in full. It also lets the bench run concurrent events on different buffers: one buffer can be aborted while another is sent, or cleared, in the same cycle.

// File: rtl/txflag_pkg.sv
package txflag_pkg;

    typedef enum logic [1:0] {
        BUF_IDLE_SENT    = 2'd0,
        BUF_IDLE_ABORTED = 2'd1,
        BUF_QUEUED       = 2'd2,
        BUF_ABORT_PEND   = 2'd3
    } buf_state_e;

    localparam int unsigned STATUS_W = 8;
    localparam int unsigned ACK_LSB  = 4;
    localparam int unsigned MAX_BUF  = 3;

endpackage

// File: rtl/txflag_cell.sv
module txflag_cell
    import txflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic clr_hit,
    input  logic req_set,
    input  logic ev_sent,
    input  logic ev_aborted,
    input  logic irq_en,
    output logic empty,
    output logic ack,
    output logic req,
    output logic irq
);

    buf_state_e state_q;
    buf_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_IDLE_SENT, BUF_IDLE_ABORTED: begin
                if (clr_hit) state_d = BUF_QUEUED;
            end
            BUF_QUEUED: begin
                if (ev_sent)      state_d = BUF_IDLE_SENT;
                else if (req_set) state_d = BUF_ABORT_PEND;
            end
            BUF_ABORT_PEND: begin
                if (ev_sent)         state_d = BUF_IDLE_SENT;
                else if (ev_aborted) state_d = BUF_IDLE_ABORTED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= BUF_IDLE_SENT;
        else if (soft_rst) state_q <= BUF_IDLE_SENT;
        else               state_q <= state_d;
    end

    // output decode
    always_comb begin
        empty = 1'b0;
        ack   = 1'b0;
        req   = 1'b0;
        unique case (state_q)
            BUF_IDLE_SENT:    empty = 1'b1;
            BUF_IDLE_ABORTED: begin empty = 1'b1; ack = 1'b1; end
            BUF_QUEUED:       ;
            BUF_ABORT_PEND:   req = 1'b1;
        endcase
        irq = empty & irq_en;
    end

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (empty && clr_hit) |=> (!empty && !ack));

    p_ack_drops_r4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        $fell(empty) |-> !ack);

    p_sent_sets_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!empty && ev_sent) |=> (empty && !ack));

    p_abort_sets_r6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (req && ev_aborted && !ev_sent) |=> (empty && ack));

    p_req_retired_r7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        $rose(empty) |-> !req);

    p_req_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (empty && req_set) |=> !req);

    p_stray_event_r9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (empty && !clr_hit) |=> (empty && $stable(ack)));

endmodule

// File: rtl/txflag_pack.sv
module txflag_pack
    import txflag_pkg::*;
#(
    parameter int unsigned NBUF = 3
) (
    input  logic [NBUF-1:0]     empty,
    input  logic [NBUF-1:0]     ack,
    output logic [STATUS_W-1:0] status
);

    localparam int unsigned SLOTS = ACK_LSB;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < NBUF) begin : g_used
            assign status[s]           = empty[s];
            assign status[ACK_LSB + s] = ack[s];
        end else begin : g_rsvd
            assign status[s]           = 1'b0;
            assign status[ACK_LSB + s] = 1'b0;
        end
    end

endmodule

// File: rtl/txbuf_status_reg.sv
module txbuf_status_reg
    import txflag_pkg::*;
#(
    parameter int unsigned NBUF = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [STATUS_W-1:0] wr_data,
    output logic [STATUS_W-1:0] status,
    input  logic [NBUF-1:0]     abort_set,
    output logic [NBUF-1:0]     abort_req,
    input  logic [NBUF-1:0]     tx_sent,
    input  logic [NBUF-1:0]     tx_aborted,
    input  logic [NBUF-1:0]     irq_en,
    output logic [NBUF-1:0]     irq
);

    logic [NBUF-1:0] empty_v;
    logic [NBUF-1:0] ack_v;
    logic            unused_wr_hi;

    assign unused_wr_hi = ^wr_data[STATUS_W-1:NBUF];

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        txflag_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (soft_rst),
            .clr_hit    (wr_en & wr_data[i]),
            .req_set    (abort_set[i]),
            .ev_sent    (tx_sent[i]),
            .ev_aborted (tx_aborted[i]),
            .irq_en     (irq_en[i]),
            .empty      (empty_v[i]),
            .ack        (ack_v[i]),
            .req        (abort_req[i]),
            .irq        (irq[i])
        );
    end

    txflag_pack #(.NBUF(NBUF)) u_pack (
        .empty  (empty_v),
        .ack    (ack_v),
        .status (status)
    );

    p_soft_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (status == 8'h07 && abort_req == '0));

    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_en) == '0);

endmodule

// File: tb/txbuf_status_reg_test.sv
`timescale 1ns/1ps
module txbuf_status_reg_test;

    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    status;
    logic [NB-1:0] abort_set = '0;
    logic [NB-1:0] abort_req;
    logic [NB-1:0] tx_sent = '0;
    logic [NB-1:0] tx_aborted = '0;
    logic [NB-1:0] irq_en = '0;
    logic [NB-1:0] irq;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_tag = "R1";

    bit m_empty [NB];
    bit m_ack   [NB];
    bit m_req   [NB];

    always #4 clk = ~clk;

    txbuf_status_reg #(.NBUF(NB)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_data(wr_data), .status(status),
        .abort_set(abort_set), .abort_req(abort_req),
        .tx_sent(tx_sent), .tx_aborted(tx_aborted),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || soft_rst) begin
            for (int i = 0; i < NB; i++) begin
                m_empty[i] = 1; m_ack[i] = 0; m_req[i] = 0;
            end
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (m_empty[i]) begin
                    if (wr_en && wr_data[i]) begin m_empty[i] = 0; m_ack[i] = 0; end
                end else if (tx_sent[i]) begin
                    m_empty[i] = 1; m_ack[i] = 0; m_req[i] = 0;
                end else if (tx_aborted[i] && m_req[i]) begin
                    m_empty[i] = 1; m_ack[i] = 1; m_req[i] = 0;
                end else if (abort_set[i]) begin
                    m_req[i] = 1;
                end
            end
        end
    end

    function automatic logic [7:0] m_status();
        logic [7:0] s = '0;
        for (int i = 0; i < NB; i++) begin
            s[i] = m_empty[i];
            s[4+i] = m_ack[i];
        end
        return s;
    endfunction

    function automatic logic [7:0] m_reqv();
        logic [7:0] r = '0;
        for (int i = 0; i < NB; i++) r[i] = m_req[i];
        return r;
    endfunction

    function automatic logic [7:0] m_irqv();
        logic [7:0] r = '0;
        for (int i = 0; i < NB; i++) r[i] = m_empty[i] & irq_en[i];
        return r;
    endfunction

    // per-clock comparison against the model (R11 covers irq)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_tag, " status"}, status, m_status());
            chk({cur_tag, " abort_req"}, {5'b0, abort_req}, m_reqv());
            chk("R11 irq", {5'b0, irq}, m_irqv());
        end
    end

    // one cycle of stimulus, applied just after a rising edge
    task automatic step(input logic w, input logic [7:0] d, input logic [NB-1:0] s,
                        input logic [NB-1:0] snt, input logic [NB-1:0] abt);
        @(posedge clk); #2;
        wr_en = w; wr_data = d; abort_set = s; tx_sent = snt; tx_aborted = abt;
        @(posedge clk); #2;
        wr_en = 0; wr_data = '0; abort_set = '0; tx_sent = '0; tx_aborted = '0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        irq_en = 3'b101;
        #1; settle();
        chk("R1 reset status", status, 8'h07);
        chk("R1 reset req", {5'b0, abort_req}, 8'h00);
        chk("R11 reset irq", {5'b0, irq}, 8'h05);
        rst_n = 1;
        repeat (2) @(posedge clk);

        cur_tag = "R3";
        step(1, 8'hF8, '0, '0, '0); settle();
        chk("R3 upper bits ignored", status, 8'h07);
        step(1, 8'h01, '0, '0, '0); settle();
        chk("R3 clear buf0", status, 8'h06);
        chk("R11 irq after clear", {5'b0, irq}, 8'h04);
        step(1, 8'h00, '0, '0, '0); settle();
        chk("R3 write zero", status, 8'h06);

        cur_tag = "R8";
        step(0, 8'h00, 3'b101, '0, '0); settle();
        chk("R8 req only on full", {5'b0, abort_req}, 8'h01);

        cur_tag = "R6";
        step(0, 8'h00, '0, '0, 3'b001); settle();
        chk("R6 abort acked", status, 8'h17);
        chk("R7 req retired", {5'b0, abort_req}, 8'h00);

        cur_tag = "R4";
        step(1, 8'h01, '0, '0, '0); settle();
        chk("R4 ack cleared with empty", status, 8'h06);

        cur_tag = "R9";
        step(0, 8'h00, '0, 3'b010, 3'b100); settle();
        chk("R9 events on empty ignored", status, 8'h06);
        step(0, 8'h00, '0, '0, 3'b001); settle();
        chk("R9 abort without request ignored", status, 8'h06);

        cur_tag = "R5";
        step(1, 8'h02, '0, '0, '0); settle();
        step(0, 8'h00, 3'b010, '0, '0); settle();
        chk("R8 req on buf1", {5'b0, abort_req}, 8'h02);
        step(0, 8'h00, '0, 3'b011, '0); settle();
        chk("R5 sent beats pending abort", status, 8'h07);
        chk("R7 req cleared on sent", {5'b0, abort_req}, 8'h00);

        cur_tag = "R10";
        step(1, 8'h04, '0, '0, '0); settle();
        step(1, 8'h04, '0, 3'b100, '0); settle();
        chk("R10 set wins over clear", status, 8'h07);

        cur_tag = "R2";
        step(1, 8'h07, '0, '0, '0); settle();
        step(0, 8'h00, 3'b111, '0, '0); settle();
        step(0, 8'h00, '0, 3'b010, 3'b101); settle();
        chk("R2 layout ack2 ack0 empty all", status, 8'h57);

        cur_tag = "R1";
        step(1, 8'h07, '0, '0, '0); settle();
        step(0, 8'h00, 3'b111, '0, '0);
        @(posedge clk); #2; soft_rst = 1;
        @(posedge clk); #2;
        step(1, 8'h07, 3'b111, '0, '0); settle();
        chk("R1 soft hold status", status, 8'h07);
        chk("R1 soft hold req", {5'b0, abort_req}, 8'h00);
        soft_rst = 0;

        cur_tag = "R5 mix";
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [NB-1:0] snt, abt;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            snt = lfsr[2:0] & {3{lfsr[9]}};
            abt = lfsr[5:3] & ~snt;
            irq_en = lfsr[12:10];
            step(lfsr[15], {lfsr[7:6], 3'b0, lfsr[8], lfsr[14], lfsr[11]} | {1'b1, 7'b0},
                 lfsr[13:11], snt, abt);
        end
        settle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule